// File: doc/BRIEF.md
# Breakpoint context extension matcher

This block keeps a bank of 32-bit extension values, one for each hardware breakpoint slot. It compares each stored value against either the current virtual machine identifier or the hypervisor-level context identifier. A 4-bit type field for each slot selects the comparison. When the top two type bits are `10`, the slot compares a VMID. When they are `11`, it compares a full 32-bit context ID. Any other type disables the slot.

Three feature straps and one configuration bit gate the comparison:

- a strap that says a hypervisor level exists;
- a strap for 16-bit VMID support;
- the 16-bit VMID enable;
- a strap for the context-ID debug extension.

Together these also set how many bits of the stored value take part in the compare.

Software-visible reads return the stored value with its reserved bits forced to zero. The masking happens at read time under the type and straps in effect at that moment, so bits hidden by the current setup are kept and come back if the setup changes. Only the first `NUM_BREAKPOINTS` slots are implemented. Writes to higher slots have no effect, and reads of them return zero. The per-slot match flags are combinational on the stored values and the current identifiers. The rest of the breakpoint unit combines them with address matching.

Top module: `bkpt_ctx_match`

## Requirements
- R1: After reset every slot holds zero, so every read returns 0.
- R2: A write with `wr_en` high to a slot index below `NUM_BREAKPOINTS` stores `wr_data`, and a read of that slot reflects it from the next cycle on. `rd_data` follows `rd_idx` combinationally.
- R3: A write to an index at or above `NUM_BREAKPOINTS` is ignored. A read of such an index returns 0, and its match flag stays 0.
- R4: In VMID mode (type bits [3:2] = `10`, hypervisor strap 1) with the 16-bit VMID strap or the enable at 0, reads show only bits [7:0], and the match compares stored bits [7:0] with `cur_vmid[7:0]`.
- R5: In VMID mode with both the 16-bit VMID strap and enable at 1, reads show bits [15:0], the match compares 16 bits, and bits [31:16] read as 0.
- R6: In context mode (type bits [3:2] = `11`, hypervisor strap 1, context-ID extension strap 1), reads show all 32 bits, and the match requires equality with `cur_ctxid`.
- R7: With type `11xx` and the context-ID extension strap 0, or with type `1xxx` and the hypervisor strap 0, the slot reads 0 and never matches.
- R8: A type with bit 3 = 0 reads 0 and never matches.
- R9: Masking never changes storage. Bits hidden under one type or strap setting read back unchanged once a setting that exposes them is applied.
- R10: A match flag is 1 only for an implemented slot whose type is VMID mode or context mode with the required straps, and whose masked compare is equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDX_W | Slot written |
| wr_data | input | DATA_W | Value written |
| rd_idx | input | IDX_W | Slot read |
| rd_data | output | DATA_W | Masked value of slot `rd_idx` |
| bp_type | input | SLOTS*4 | Type field of each slot, slot i at bits [4i+3:4i] |
| cur_vmid | input | 16 | Current virtual machine ID |
| cur_ctxid | input | DATA_W | Current hypervisor-level context ID |
| hyp_present | input | 1 | Hypervisor level implemented |
| vmid16_present | input | 1 | 16-bit VMID supported |
| vmid16_en | input | 1 | 16-bit VMID enabled |
| ctx2_present | input | 1 | Context-ID debug extension implemented |
| match | output | SLOTS | Per-slot context match flags |

## Verification
The assertions check on every cycle that reads obey the reserved-zero rules for the type of the selected slot. They also check that any raised match flag belongs to a context-capable slot under a present hypervisor level, that a legal write lands in storage by the next cycle, and that storage is unchanged in cycles without a write. Only the bench scenarios can show that hidden bits survive a change of type or strap. They also show that the compare width really narrows and widens with the VMID straps, that writes above the implemented count vanish, and that match flags agree with an independent model across random contents and identifiers.

// File: rtl/bkpt_ctx_pkg.sv
package bkpt_ctx_pkg;

   localparam int TYPE_W = 4;

   typedef enum logic [1:0] {
      CMP_OFF  = 2'd0,
      CMP_VMID = 2'd1,
      CMP_CTX  = 2'd2
   } cmp_mode_e;

   // Type bits [3:2] pick the comparison; straps can still disable it.
   function automatic cmp_mode_e decode_mode(input logic [TYPE_W-1:0] ty,
                                             input logic hyp,
                                             input logic ctx2);
      cmp_mode_e m;
      m = CMP_OFF;
      if (hyp && ty[3:2] == 2'b10)
         m = CMP_VMID;
      else if (hyp && ctx2 && ty[3:2] == 2'b11)
         m = CMP_CTX;
      return m;
   endfunction

endpackage

// File: rtl/bkpt_ctx_bank.sv
module bkpt_ctx_bank #(
   parameter int SLOTS    = 16,
   parameter int IMPL     = 16,
   parameter int DATA_W   = 32,
   localparam int IDX_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [IDX_W-1:0]        wr_idx,
   input  logic [DATA_W-1:0]       wr_data,
   output logic [SLOTS*DATA_W-1:0] q_flat
);

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      if (i < IMPL) begin : g_impl
         logic [DATA_W-1:0] q;
         logic              sel;

         assign sel = wr_en && (int'(wr_idx) == i);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (sel) q <= wr_data;
         end

         assign q_flat[i*DATA_W +: DATA_W] = q;

         // R2: a legal write is visible in storage on the next cycle
         p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && int'(wr_idx) == i) |=> q_flat[i*DATA_W +: DATA_W] == $past(wr_data));

         // R9: storage only moves on a write
         p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> $stable(q_flat[i*DATA_W +: DATA_W]));
      end else begin : g_absent
         assign q_flat[i*DATA_W +: DATA_W] = '0;
      end
   end

endmodule

// File: rtl/bkpt_ctx_slot.sv
module bkpt_ctx_slot
   import bkpt_ctx_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int VMID_W    = 16,
   parameter int VMID_LO_W = 8
) (
   input  logic [DATA_W-1:0] stored,
   input  logic [TYPE_W-1:0] ty,
   input  logic              hyp_present,
   input  logic              vmid_wide,
   input  logic              ctx2_present,
   input  logic [VMID_W-1:0] cur_vmid,
   input  logic [DATA_W-1:0] cur_ctxid,
   output logic [DATA_W-1:0] view,
   output logic              hit
);

   localparam logic [DATA_W-1:0] MASK_LO   = DATA_W'({VMID_LO_W{1'b1}});
   localparam logic [DATA_W-1:0] MASK_WIDE = DATA_W'({VMID_W{1'b1}});

   cmp_mode_e         mode;
   logic [DATA_W-1:0] mask;
   logic [DATA_W-1:0] ref_val;

   always_comb begin
      mode = decode_mode(ty, hyp_present, ctx2_present);
      unique case (mode)
         CMP_VMID: begin
            mask    = vmid_wide ? MASK_WIDE : MASK_LO;
            ref_val = DATA_W'(cur_vmid);
         end
         CMP_CTX: begin
            mask    = '1;
            ref_val = cur_ctxid;
         end
         default: begin
            mask    = '0;
            ref_val = '0;
         end
      endcase
      view = stored & mask;
      hit  = (mode != CMP_OFF) && (view == (ref_val & mask));
   end

endmodule

// File: rtl/bkpt_ctx_match.sv
module bkpt_ctx_match
   import bkpt_ctx_pkg::*;
#(
   parameter int SLOTS           = 16,
   parameter int NUM_BREAKPOINTS = 16,
   parameter int DATA_W          = 32,
   parameter int VMID_W          = 16,
   parameter int VMID_LO_W       = 8,
   localparam int IDX_W          = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [IDX_W-1:0]        wr_idx,
   input  logic [DATA_W-1:0]       wr_data,
   input  logic [IDX_W-1:0]        rd_idx,
   output logic [DATA_W-1:0]       rd_data,
   input  logic [SLOTS*TYPE_W-1:0] bp_type,
   input  logic [VMID_W-1:0]       cur_vmid,
   input  logic [DATA_W-1:0]       cur_ctxid,
   input  logic                    hyp_present,
   input  logic                    vmid16_present,
   input  logic                    vmid16_en,
   input  logic                    ctx2_present,
   output logic [SLOTS-1:0]        match
);

   if (NUM_BREAKPOINTS < 1 || NUM_BREAKPOINTS > SLOTS) begin : g_bad_count
      $error("NUM_BREAKPOINTS must lie in 1..SLOTS");
   end
   if (VMID_LO_W > VMID_W || VMID_W > DATA_W) begin : g_bad_width
      $error("VMID widths must satisfy VMID_LO_W <= VMID_W <= DATA_W");
   end

   logic [SLOTS*DATA_W-1:0] q_flat;
   logic [SLOTS*DATA_W-1:0] view_flat;
   logic                    vmid_wide;

   assign vmid_wide = vmid16_present && vmid16_en;

   bkpt_ctx_bank #(
      .SLOTS  (SLOTS),
      .IMPL   (NUM_BREAKPOINTS),
      .DATA_W (DATA_W)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .q_flat  (q_flat)
   );

   for (genvar i = 0; i < SLOTS; i++) begin : g_cmp
      if (i < NUM_BREAKPOINTS) begin : g_impl
         bkpt_ctx_slot #(
            .DATA_W    (DATA_W),
            .VMID_W    (VMID_W),
            .VMID_LO_W (VMID_LO_W)
         ) u_slot (
            .stored       (q_flat[i*DATA_W +: DATA_W]),
            .ty           (bp_type[i*TYPE_W +: TYPE_W]),
            .hyp_present  (hyp_present),
            .vmid_wide    (vmid_wide),
            .ctx2_present (ctx2_present),
            .cur_vmid     (cur_vmid),
            .cur_ctxid    (cur_ctxid),
            .view         (view_flat[i*DATA_W +: DATA_W]),
            .hit          (match[i])
         );

         // R10: a hit needs a context-capable type and a hypervisor level
         p_hit_capable_r10: assert property (@(posedge clk) disable iff (!rst_n)
            match[i] |-> (bp_type[i*TYPE_W+3] && hyp_present));
      end else begin : g_absent
         assign view_flat[i*DATA_W +: DATA_W] = '0;
         assign match[i] = 1'b0;
      end
   end

   always_comb begin
      rd_data = '0;
      if (int'(rd_idx) < NUM_BREAKPOINTS)
         rd_data = view_flat[int'(rd_idx)*DATA_W +: DATA_W];
   end

   logic [TYPE_W-1:0] rd_ty;
   assign rd_ty = (int'(rd_idx) < SLOTS) ? bp_type[int'(rd_idx)*TYPE_W +: TYPE_W] : '0;

   // R8: a disabled type reads as zero
   p_off_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_ty[3] |-> rd_data == '0);

   // R4: narrow VMID hides everything above the low byte
   p_narrow_vmid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ty[3:2] == 2'b10 && !vmid_wide) |-> (rd_data >> VMID_LO_W) == '0);

   // R5: wide VMID still hides the upper half
   p_wide_vmid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ty[3:2] == 2'b10) |-> (rd_data >> VMID_W) == '0);

   // R7: context mode without its extension strap reads as zero
   p_ctx_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_ty[3:2] == 2'b11 && !ctx2_present) || !hyp_present) |-> rd_data == '0);

   // R3: unimplemented slots never raise a flag
   p_absent_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (match >> NUM_BREAKPOINTS) == '0);

endmodule

// File: tb/sim_bkpt_ctx_match.sv
module sim_bkpt_ctx_match;

   localparam int SLOTS = 16;
   localparam int NB    = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  rd_idx = '0;
   logic [31:0] rd_data;
   logic [63:0] bp_type = '0;
   logic [15:0] cur_vmid = '0;
   logic [31:0] cur_ctxid = '0;
   logic        hyp_present = 1'b1;
   logic        vmid16_present = 1'b0;
   logic        vmid16_en = 1'b0;
   logic        ctx2_present = 1'b1;
   logic [15:0] match;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 0;
   logic [31:0] model [SLOTS];

   always #4 clk = ~clk;

   bkpt_ctx_match #(.SLOTS(SLOTS), .NUM_BREAKPOINTS(NB)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx(rd_idx), .rd_data(rd_data), .bp_type(bp_type), .cur_vmid(cur_vmid),
      .cur_ctxid(cur_ctxid), .hyp_present(hyp_present), .vmid16_present(vmid16_present),
      .vmid16_en(vmid16_en), .ctx2_present(ctx2_present), .match(match)
   );

   function automatic logic [31:0] exp_mask(int i);
      logic [3:0] t;
      t = bp_type[i*4 +: 4];
      if (i >= NB || !hyp_present) return 32'h0;
      if (t[3:2] == 2'b10) return (vmid16_present && vmid16_en) ? 32'h0000_FFFF : 32'h0000_00FF;
      if (t[3:2] == 2'b11 && ctx2_present) return 32'hFFFF_FFFF;
      return 32'h0;
   endfunction

   function automatic logic [31:0] exp_view(int i);
      return model[i] & exp_mask(i);
   endfunction

   function automatic logic exp_hit(int i);
      logic [31:0] m;
      logic [31:0] r;
      m = exp_mask(i);
      if (m == 32'h0) return 1'b0;
      r = (bp_type[i*4+2]) ? cur_ctxid : {16'h0, cur_vmid};
      return (model[i] & m) == (r & m);
   endfunction

   function automatic string tag_of(int i);
      logic [3:0] t;
      t = bp_type[i*4 +: 4];
      if (i >= NB) return "R3";
      if (!t[3]) return "R8";
      if (!hyp_present) return "R7";
      if (t[2] && !ctx2_present) return "R7";
      if (t[2]) return "R6";
      if (vmid16_present && vmid16_en) return "R5";
      return "R4";
   endfunction

   task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic check_all();
      logic [15:0] em;
      for (int i = 0; i < SLOTS; i++) begin
         rd_idx = 4'(i);
         #1;
         check(tag_of(i), $sformatf("read slot %0d", i), rd_data, exp_view(i));
      end
      for (int i = 0; i < SLOTS; i++) em[i] = exp_hit(i);
      check("R10", "match vector", {16'h0, match}, {16'h0, em});
   endtask

   task automatic do_write(int idx, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 4'(idx); wr_data = d;
      @(posedge clk);
      if (idx < NB) model[idx] = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_type(int i, logic [3:0] t);
      bp_type[i*4 +: 4] = t;
   endtask

   initial begin
      int seed;
      seed = $urandom(32'd20240611);
      for (int i = 0; i < SLOTS; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset contents, shown through the widest view
      for (int i = 0; i < SLOTS; i++) set_type(i, 4'b1100);
      cur_ctxid = 32'h1;
      for (int i = 0; i < SLOTS; i++) begin
         rd_idx = 4'(i);
         #1;
         check("R1", "reset read", rd_data, 32'h0);
      end
      check("R1", "reset match", {16'h0, match}, 32'h0);

      // R9, R2: hidden bits survive type and strap changes
      set_type(3, 4'b0000);
      do_write(3, 32'hDEAD_BEEF);
      rd_idx = 4'd3; #1;
      check("R8", "off type hides", rd_data, 32'h0);
      set_type(3, 4'b1000); #1;
      check("R4", "narrow vmid view", rd_data, 32'h0000_00EF);
      vmid16_present = 1'b1; #1;
      check("R4", "strap without enable", rd_data, 32'h0000_00EF);
      vmid16_en = 1'b1; #1;
      check("R5", "wide vmid view", rd_data, 32'h0000_BEEF);
      cur_vmid = 16'hBEEF; #1;
      check("R5", "wide vmid hit", 32'(match[3]), 32'h1);
      cur_vmid = 16'h12EF; #1;
      check("R5", "wide vmid upper miss", 32'(match[3]), 32'h0);
      vmid16_en = 1'b0; #1;
      check("R4", "narrow compare ignores upper byte", 32'(match[3]), 32'h1);
      set_type(3, 4'b1101); ctx2_present = 1'b0; #1;
      check("R7", "ctx without extension", rd_data, 32'h0);
      ctx2_present = 1'b1; cur_ctxid = 32'hDEAD_BEEF; #1;
      check("R9", "full value returns", rd_data, 32'hDEAD_BEEF);
      check("R6", "ctx hit", 32'(match[3]), 32'h1);
      hyp_present = 1'b0; #1;
      check("R7", "no hypervisor level", rd_data, 32'h0);
      check("R7", "no hypervisor no hit", {16'h0, match}, 32'h0);
      hyp_present = 1'b1;

      // R3: writes above the implemented count vanish
      set_type(13, 4'b1100);
      do_write(13, 32'hCAFE_F00D);
      cur_ctxid = 32'hCAFE_F00D;
      rd_idx = 4'd13; #1;
      check("R3", "absent slot read", rd_data, 32'h0);
      check("R3", "absent slot match", 32'(match[13]), 32'h0);
      check_all();

      // Random mix
      for (int it = 0; it < 400; it++) begin
         int k;
         k = int'($urandom_range(0, 15));
         if ($urandom_range(0, 2) != 0)
            do_write(int'($urandom_range(0, 15)), $urandom());
         @(negedge clk);
         bp_type = {$urandom(), $urandom()};
         hyp_present    = ($urandom_range(0, 7) != 0);
         vmid16_present = $urandom_range(0, 1) != 0;
         vmid16_en      = $urandom_range(0, 1) != 0;
         ctx2_present   = ($urandom_range(0, 3) != 0);
         case ($urandom_range(0, 2))
            0: begin cur_vmid = model[k][15:0]; cur_ctxid = model[k]; end
            1: begin cur_vmid = {$urandom_range(0, 255)} [15:0] ^ model[k][15:0] & 16'hFF00; cur_ctxid = $urandom(); end
            default: begin cur_vmid = 16'($urandom()); cur_ctxid = $urandom(); end
         endcase
         check_all();
      end

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(8 * 190000);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule